// File: doc/BRIEF.md
# Request-Paced Byte Mover Channel

This block is one channel that copies a run of bytes from a source location to a destination location. Each endpoint can be either external memory, with a full 16-bit address, or an on-chip peripheral register. A peripheral register is selected by the low address byte alone. A typical use feeds a serial transmitter's holding register from a memory buffer, or drains a receiver's holding register into memory. Software programs the channel through a byte-wide write port with eight register slots. The last control write sets the enable bit and launches the run.

Each byte is moved in two phases. First a read on the read channel fills an internal holding byte. Then a write on the write channel delivers that byte. At most one byte is in flight at a time.

Both bus channels use valid/ready handshakes. A channel raises valid and keeps valid, the address, the space flag and (on writes) the data stable until the cycle in which ready is high. That cycle is the handshake. Holding ready low stalls the channel for as long as needed.

The channel can run in two ways:
- **Paced mode:** a byte starts only when the peripheral request is high. The peripheral receives a one-cycle acknowledge as each write completes.
- **Free-running mode:** bytes move back to back until the count is used up.

When the count is used up, the channel stops and raises a done flag.

Top module: `pdma_channel`

## Requirements
- R1: After reset, `rd_valid`, `wr_valid`, `per_ack`, `xfer_done` and `chan_run` are all 0.
- R2: Each byte moves in a fixed order:
  - first one read, held until `rd_ready`;
  - then, from the following cycle, one write of the byte just read, held with stable address and data until `wr_ready`.
  - `rd_valid` and `wr_valid` are never high together.
- R3: Register slots are 0 control, 1 source low, 2 source high, 3 destination low, 4 destination high, 5 count low, 6 count high, 7 flag clear.
  - Control bit 5 (source) and bit 7 (destination) select peripheral space. An endpoint in peripheral space presents address `{8'h00, low byte}` with its space flag at 1.
  - An endpoint in memory space presents the full 16-bit address with its space flag at 0.
- R4: Control bit 4 enables source auto-increment and bit 6 enables destination auto-increment. The address steps after each write handshake.
  - A memory address wraps at 16 bits.
  - A peripheral address increments only its low byte, wrapping within 8 bits.
  - An endpoint without auto-increment keeps its address for the whole run.
- R5: The run is paced when control bit 2 is 0 and bit 3 is 1.
  - In paced mode, a byte starts only from an idle cycle in which `per_req` is high. `per_ack` pulses for exactly the write-handshake cycle.
  - In any other setting, bytes start back to back, `per_req` is ignored and `per_ack` stays 0.
- R6: Writing the control slot with bit 0 set while the channel is stopped starts a run.
  - The start samples the 16-bit count from slots 5/6 and the addresses from slots 1–4.
  - The run moves exactly that many bytes, decrementing once per byte.
  - `chan_run` is high for the duration of the run.
- R7: One cycle after the final write handshake, `xfer_done` rises and `chan_run` falls. No further reads occur, however long `per_req` stays high.
- R8: A run started with a count of zero moves no byte and raises `xfer_done`.
- R9: While `chan_run` is high, writes to slots 0–6 are ignored.
- R10: `xfer_done` is cleared by writing slot 7 with bit 0 set, or by a new start. If a clear arrives in the same cycle that done is being set, done stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register slot select |
| cfg_wdata | input | 8 | Register write data |
| per_req | input | 1 | Peripheral request |
| per_ack | output | 1 | One-cycle acknowledge per completed byte (paced mode) |
| rd_valid | output | 1 | Read channel valid |
| rd_ready | input | 1 | Read channel ready; data accepted in the handshake cycle |
| rd_addr | output | 16 | Read address |
| rd_space | output | 1 | Read target: 1 peripheral register, 0 memory |
| rd_data | input | 8 | Read data, sampled on the read handshake |
| wr_valid | output | 1 | Write channel valid |
| wr_ready | input | 1 | Write channel ready |
| wr_addr | output | 16 | Write address |
| wr_space | output | 1 | Write target: 1 peripheral register, 0 memory |
| wr_data | output | 8 | Write data |
| xfer_done | output | 1 | Run finished flag |
| chan_run | output | 1 | Channel enabled (control bit 0) |

## Verification
Two events can land on the same clock edge: the hardware setting the done flag after the final byte, and a software write to the flag-clear slot. The bench watches its own reference model. On the negative edge where the model is idle with the channel enabled and zero bytes left, it drives a clear write, so that the clear and the set meet on the next edge. The done output must read 1 afterwards. A second clear with nothing competing must bring it to 0.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef logic [2:0] reg_sel_t;

  localparam reg_sel_t RG_CTRL   = 3'd0;
  localparam reg_sel_t RG_SRC_LO = 3'd1;
  localparam reg_sel_t RG_SRC_HI = 3'd2;
  localparam reg_sel_t RG_DST_LO = 3'd3;
  localparam reg_sel_t RG_DST_HI = 3'd4;
  localparam reg_sel_t RG_CNT_LO = 3'd5;
  localparam reg_sel_t RG_CNT_HI = 3'd6;
  localparam reg_sel_t RG_CLEAR  = 3'd7;

  localparam int CB_EN     = 0;
  localparam int CB_MODE   = 2;
  localparam int CB_DEMAND = 3;
  localparam int CB_SINC   = 4;
  localparam int CB_SSFR   = 5;
  localparam int CB_DINC   = 6;
  localparam int CB_DSFR   = 7;

  typedef struct packed {
    logic dsfr;
    logic dinc;
    logic ssfr;
    logic sinc;
    logic demand;
    logic mode;
    logic en;
  } chan_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } mover_state_e;

endpackage

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen #(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [2*HALF_W-1:0] load_val_i,
  input  logic                step_i,
  input  logic                inc_i,
  input  logic                sfr_i,
  output logic [2*HALF_W-1:0] addr_o,
  output logic                space_o
);

  localparam int FULL_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};
  localparam logic [FULL_W-1:0] ONE_F = {{(FULL_W-1){1'b0}}, 1'b1};

  logic [FULL_W-1:0] cur_q;
  logic [FULL_W-1:0] nxt;

  always_comb begin
    if (sfr_i) nxt = {cur_q[FULL_W-1:HALF_W], cur_q[HALF_W-1:0] + ONE_H};
    else       nxt = cur_q + ONE_F;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur_q <= '0;
    else if (load_i)           cur_q <= load_val_i;
    else if (step_i && inc_i)  cur_q <= nxt;
  end

  assign addr_o  = sfr_i ? {{HALF_W{1'b0}}, cur_q[HALF_W-1:0]} : cur_q;
  assign space_o = sfr_i;

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_init_i,
  input  logic              paced_i,
  input  logic              req_i,
  input  logic              rd_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wr_ready_i,
  output logic              rd_valid_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              step_o,
  output logic              ack_o,
  output logic              finish_o
);

  localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

  mover_state_e      state_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] hold_q;
  logic              left_zero;
  logic              go;
  logic              wr_hs;

  assign left_zero = (left_q == '0);
  assign go        = run_i && !left_zero && (!paced_i || req_i);
  assign wr_hs     = (state_q == ST_WRITE) && wr_ready_i;
  assign finish_o  = (state_q == ST_IDLE) && run_i && left_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (start_i) left_q <= cnt_init_i;
    else if (wr_hs)   left_q <= left_q - ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (go) state_q <= ST_READ;
        ST_READ:  if (rd_ready_i) begin
                    hold_q  <= rd_data_i;
                    state_q <= ST_WRITE;
                  end
        ST_WRITE: if (wr_ready_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid_o = (state_q == ST_READ);
  assign wr_valid_o = (state_q == ST_WRITE);
  assign wr_data_o  = hold_q;
  assign step_o     = wr_hs;
  assign ack_o      = wr_hs && paced_i;

endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  reg_sel_t           cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               finish_i,
  output chan_ctrl_t         ctrl_o,
  output logic               start_o,
  output logic               done_o,
  output logic [2*REG_W-1:0] src_cfg_o,
  output logic [2*REG_W-1:0] dst_cfg_o,
  output logic [2*REG_W-1:0] cnt_cfg_o
);

  chan_ctrl_t       ctrl_q;
  logic [REG_W-1:0] src_lo_q, src_hi_q, dst_lo_q, dst_hi_q, cnt_lo_q, cnt_hi_q;
  logic             done_q;
  logic             wr_open;
  logic             clr_hit;

  assign wr_open = cfg_we && !ctrl_q.en;
  assign start_o = wr_open && (cfg_addr == RG_CTRL) && cfg_wdata[CB_EN];
  assign clr_hit = cfg_we && (cfg_addr == RG_CLEAR) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      src_lo_q <= '0;
      src_hi_q <= '0;
      dst_lo_q <= '0;
      dst_hi_q <= '0;
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (wr_open) begin
        case (cfg_addr)
          RG_CTRL: begin
            ctrl_q.en     <= cfg_wdata[CB_EN];
            ctrl_q.mode   <= cfg_wdata[CB_MODE];
            ctrl_q.demand <= cfg_wdata[CB_DEMAND];
            ctrl_q.sinc   <= cfg_wdata[CB_SINC];
            ctrl_q.ssfr   <= cfg_wdata[CB_SSFR];
            ctrl_q.dinc   <= cfg_wdata[CB_DINC];
            ctrl_q.dsfr   <= cfg_wdata[CB_DSFR];
          end
          RG_SRC_LO: src_lo_q <= cfg_wdata;
          RG_SRC_HI: src_hi_q <= cfg_wdata;
          RG_DST_LO: dst_lo_q <= cfg_wdata;
          RG_DST_HI: dst_hi_q <= cfg_wdata;
          RG_CNT_LO: cnt_lo_q <= cfg_wdata;
          RG_CNT_HI: cnt_hi_q <= cfg_wdata;
          default: ;
        endcase
      end
      if (finish_i) begin
        ctrl_q.en <= 1'b0;
        done_q    <= 1'b1;
      end else if (start_o || clr_hit) begin
        done_q    <= 1'b0;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign done_o    = done_q;
  assign src_cfg_o = {src_hi_q, src_lo_q};
  assign dst_cfg_o = {dst_hi_q, dst_lo_q};
  assign cnt_cfg_o = {cnt_hi_q, cnt_lo_q};

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               per_req,
  output logic               per_ack,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [2*REG_W-1:0] rd_addr,
  output logic               rd_space,
  input  logic [REG_W-1:0]   rd_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [2*REG_W-1:0] wr_addr,
  output logic               wr_space,
  output logic [REG_W-1:0]   wr_data,
  output logic               xfer_done,
  output logic               chan_run
);

  localparam int ADDR_W = 2 * REG_W;
  localparam int CNT_W  = 2 * REG_W;
  localparam int N_EP   = 2;

  chan_ctrl_t        ctrl;
  logic              start;
  logic              finish;
  logic              step;
  logic              paced;
  logic [ADDR_W-1:0] src_cfg, dst_cfg;
  logic [CNT_W-1:0]  cnt_cfg;

  logic [ADDR_W-1:0] ep_cfg   [N_EP];
  logic              ep_inc   [N_EP];
  logic              ep_sfr   [N_EP];
  logic [ADDR_W-1:0] ep_addr  [N_EP];
  logic              ep_space [N_EP];

  pdma_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .finish_i  (finish),
    .ctrl_o    (ctrl),
    .start_o   (start),
    .done_o    (xfer_done),
    .src_cfg_o (src_cfg),
    .dst_cfg_o (dst_cfg),
    .cnt_cfg_o (cnt_cfg)
  );

  assign paced = !ctrl.mode && ctrl.demand;

  assign ep_cfg[0] = src_cfg;
  assign ep_inc[0] = ctrl.sinc;
  assign ep_sfr[0] = ctrl.ssfr;
  assign ep_cfg[1] = dst_cfg;
  assign ep_inc[1] = ctrl.dinc;
  assign ep_sfr[1] = ctrl.dsfr;

  for (genvar e = 0; e < N_EP; e++) begin : g_ep
    pdma_addr_gen #(.HALF_W(REG_W)) u_ag (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start),
      .load_val_i (ep_cfg[e]),
      .step_i     (step),
      .inc_i      (ep_inc[e]),
      .sfr_i      (ep_sfr[e]),
      .addr_o     (ep_addr[e]),
      .space_o    (ep_space[e])
    );
  end

  pdma_seq #(.CNT_W(CNT_W), .DATA_W(REG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (ctrl.en),
    .start_i    (start),
    .cnt_init_i (cnt_cfg),
    .paced_i    (paced),
    .req_i      (per_req),
    .rd_ready_i (rd_ready),
    .rd_data_i  (rd_data),
    .wr_ready_i (wr_ready),
    .rd_valid_o (rd_valid),
    .wr_valid_o (wr_valid),
    .wr_data_o  (wr_data),
    .step_o     (step),
    .ack_o      (per_ack),
    .finish_o   (finish)
  );

  assign rd_addr  = ep_addr[0];
  assign rd_space = ep_space[0];
  assign wr_addr  = ep_addr[1];
  assign wr_space = ep_space[1];
  assign chan_run = ctrl.en;

endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
  parameter int REG_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               per_ack,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [2*REG_W-1:0] rd_addr,
  input logic               rd_space,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [2*REG_W-1:0] wr_addr,
  input logic               wr_space,
  input logic [REG_W-1:0]   wr_data,
  input logic               xfer_done,
  input logic               chan_run
);

  localparam int ADDR_W = 2 * REG_W;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_space));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> wr_valid);

  // R3
  rd_sfr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_space |-> rd_addr[ADDR_W-1:REG_W] == '0);

  // R3
  wr_sfr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_space |-> wr_addr[ADDR_W-1:REG_W] == '0);

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  // R5
  ack_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> wr_valid && wr_ready);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !chan_run && !rd_valid && !wr_valid);

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> $fell(chan_run));

endmodule

bind pdma_channel pdma_channel_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .per_ack   (per_ack),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .rd_space  (rd_space),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_space  (wr_space),
  .wr_data   (wr_data),
  .xfer_done (xfer_done),
  .chan_run  (chan_run)
);

// File: tb/sim_pdma_channel.sv
module sim_pdma_channel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic        per_req = 1'b0;
  logic        rd_ready = 1'b0;
  logic        wr_ready = 1'b0;
  logic        per_ack, rd_valid, rd_space, wr_valid, wr_space, xfer_done, chan_run;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;

  pdma_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .per_req(per_req), .per_ack(per_ack), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_space(rd_space), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_space(wr_space), .wr_data(wr_data),
    .xfer_done(xfer_done), .chan_run(chan_run)
  );

  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic [7:0] mem_fn(logic [15:0] a, logic sp);
    return a[7:0] ^ a[15:8] ^ (sp ? 8'hC3 : 8'h3C);
  endfunction
  assign rd_data = mem_fn(rd_addr, rd_space);

  function automatic logic [15:0] ep_out(logic [15:0] a, logic sfr);
    return sfr ? {8'h00, a[7:0]} : a;
  endfunction

  function automatic logic [15:0] ep_step(logic [15:0] a, logic sfr);
    logic [7:0] lo;
    lo = a[7:0] + 8'd1;
    return sfr ? {a[15:8], lo} : a + 16'd1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ms;
  int          mcnt;
  logic [7:0]  mc, sl, sh, dl, dh, cl, ch, mhold;
  logic [15:0] msrc, mdst;
  logic        md, m_run_o, m_paced, m_fin, m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mc = 0; sl = 0; sh = 0; dl = 0; dh = 0; cl = 0; ch = 0;
      mhold = 0; msrc = 0; mdst = 0; md = 0;
    end else begin
      m_run_o = mc[0];
      m_paced = !mc[2] && mc[3];
      m_fin   = (ms == 0) && m_run_o && (mcnt == 0);
      m_start = cfg_we && (cfg_addr == 3'd0) && cfg_wdata[0] && !m_run_o;
      case (ms)
        0: if (m_run_o && mcnt != 0 && (!m_paced || per_req)) ms = 1;
        1: if (rd_ready) begin mhold = mem_fn(ep_out(msrc, mc[5]), mc[5]); ms = 2; end
        default: if (wr_ready) begin
          ms = 0;
          mcnt = mcnt - 1;
          if (mc[4]) msrc = ep_step(msrc, mc[5]);
          if (mc[6]) mdst = ep_step(mdst, mc[7]);
        end
      endcase
      if (cfg_we && !m_run_o) begin
        case (cfg_addr)
          3'd0: mc = cfg_wdata;
          3'd1: sl = cfg_wdata;
          3'd2: sh = cfg_wdata;
          3'd3: dl = cfg_wdata;
          3'd4: dh = cfg_wdata;
          3'd5: cl = cfg_wdata;
          3'd6: ch = cfg_wdata;
          default: ;
        endcase
      end
      if (m_fin) begin
        mc[0] = 1'b0;
        md = 1'b1;
      end else if (m_start || (cfg_we && cfg_addr == 3'd7 && cfg_wdata[0])) begin
        md = 1'b0;
      end
      if (m_start) begin
        mcnt = {ch, cl};
        msrc = {sh, sl};
        mdst = {dh, dl};
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rd_valid", rd_valid, ms == 1);
      if (ms == 1) begin
        chk("R3 rd_addr", rd_addr, ep_out(msrc, mc[5]));
        chk("R3 rd_space", rd_space, mc[5]);
      end
      chk("R2 wr_valid", wr_valid, ms == 2);
      if (ms == 2) begin
        chk("R3 wr_addr", wr_addr, ep_out(mdst, mc[7]));
        chk("R3 wr_space", wr_space, mc[7]);
        chk("R2 wr_data", wr_data, mhold);
      end
      chk("R5 per_ack", per_ack, (ms == 2) && wr_ready && !mc[2] && mc[3]);
      chk("R7 xfer_done", xfer_done, md);
      chk("R6 chan_run", chan_run, mc[0]);
    end
  end

  // ---------------- stimulus sources ----------------
  logic [15:0] lfsr = 16'hACE1;
  int          req_mode = 0;
  bit          rdy_rand = 1'b0;

  always @(negedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = rdy_rand ? lfsr[0] : 1'b1;
    wr_ready = rdy_rand ? lfsr[3] : 1'b1;
    case (req_mode)
      0: per_req = 1'b0;
      1: per_req = 1'b1;
      default: per_req = lfsr[5] & lfsr[7];
    endcase
  end

  int          n_wr = 0, n_rd = 0, n_ack = 0;
  logic [15:0] last_wr_addr = 16'h0, last_rd_addr = 16'h0, first_rd_addr = 16'h0;
  bit          grab_first = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin n_wr++; last_wr_addr = wr_addr; end
      if (rd_valid && rd_ready) begin
        n_rd++;
        last_rd_addr = rd_addr;
        if (grab_first) begin first_rd_addr = rd_addr; grab_first = 1'b0; end
      end
      if (per_ack) n_ack++;
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
    reg_wr(3'd1, s[7:0]);  reg_wr(3'd2, s[15:8]);
    reg_wr(3'd3, d[7:0]);  reg_wr(3'd4, d[15:8]);
    reg_wr(3'd5, c[7:0]);  reg_wr(3'd6, c[15:8]);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !xfer_done; i++) @(negedge clk);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  int w0, a0, r0;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 per_ack", per_ack, 0);
    chk("R1 xfer_done", xfer_done, 0);
    chk("R1 chan_run", chan_run, 0);

    // memory -> peripheral, paced, request held high, random stalls
    rdy_rand = 1'b1; req_mode = 1;
    setup(16'h1234, 16'h7785, 16'd5);
    w0 = n_wr; a0 = n_ack;
    reg_wr(3'd0, 8'h99);
    wait_done(400);
    chk("R6 bytes moved", n_wr - w0, 5);
    chk("R5 ack count", n_ack - a0, 5);
    chk("R3 sfr dest addr", last_wr_addr, 16'h0085);
    chk("R7 done set", xfer_done, 1);
    w0 = n_wr; r0 = n_rd;
    repeat (10) @(negedge clk);
    chk("R7 no reads after done", n_rd - r0, 0);
    reg_wr(3'd7, 8'h01);
    chk("R10 clear", xfer_done, 0);

    // peripheral -> memory with wrap, sparse requests, ignored writes while running
    req_mode = 2;
    setup(16'hABF4, 16'hFFFE, 16'd4);
    w0 = n_wr; grab_first = 1'b1;
    reg_wr(3'd0, 8'h69);
    reg_wr(3'd1, 8'h11);
    reg_wr(3'd5, 8'h09);
    reg_wr(3'd0, 8'h00);
    chk("R9 still running", chan_run, 1);
    wait_done(2000);
    chk("R6 bytes moved rx", n_wr - w0, 4);
    chk("R4 dest wrap", last_wr_addr, 16'h0001);
    chk("R3 hi byte ignored", first_rd_addr, 16'h00F4);
    chk("R4 src held", last_rd_addr, 16'h00F4);

    // free-running rerun with previously held settings
    req_mode = 0;
    w0 = n_wr; a0 = n_ack; grab_first = 1'b1;
    reg_wr(3'd0, 8'h21);
    chk("R10 start clears done", xfer_done, 0);
    wait_done(400);
    chk("R9 count kept", n_wr - w0, 4);
    chk("R9 src kept", first_rd_addr, 16'h00F4);
    chk("R5 free run no ack", n_ack - a0, 0);

    // peripheral source auto-increment wraps low byte, mode bit 2 set
    setup(16'h12FE, 16'h0300, 16'd3);
    w0 = n_wr; a0 = n_ack;
    reg_wr(3'd0, 8'h35);
    wait_done(400);
    chk("R4 sfr low wrap", last_rd_addr, 16'h0000);
    chk("R4 dest held", last_wr_addr, 16'h0300);
    chk("R5 mode bit no ack", n_ack - a0, 0);
    chk("R6 bytes moved sfr", n_wr - w0, 3);

    // zero count
    setup(16'h0040, 16'h0050, 16'd0);
    r0 = n_rd;
    reg_wr(3'd0, 8'h01);
    wait_done(20);
    chk("R8 done on zero", xfer_done, 1);
    chk("R8 no reads", n_rd - r0, 0);

    // clear arriving in the cycle done is set
    rdy_rand = 1'b0;
    setup(16'h0100, 16'h0200, 16'd2);
    reg_wr(3'd0, 8'h51);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ms == 0 && mc[0] && mcnt == 0) break;
    end
    #1;
    cfg_we = 1'b1; cfg_addr = 3'd7; cfg_wdata = 8'h01;
    @(negedge clk);
    chk("R10 set beats clear", xfer_done, 1);
    #1 cfg_we = 1'b0;
    reg_wr(3'd7, 8'h01);
    chk("R10 later clear", xfer_done, 0);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule